// File: doc/BRIEF.md
# Masked SIMD Even-Lane Duplicator

This block is a single registered stage in a vector datapath. It takes a source vector of up to eight 64-bit lanes. For each pair of lanes (2m, 2m+1) inside the selected vector length, it copies the even source lane into both output lanes. The stage only moves bits and never interprets the lane contents as numbers.

Three encoding classes shape the result:
- The legacy class works on 128 bits and leaves every destination bit above 128 as it was.
- The unmasked class works on 128 or 256 bits and clears everything above the active length.
- The masked class works on 128, 256 or 512 bits and applies a per-lane writemask. A lane whose mask bit is clear either keeps the old destination lane (merge) or is cleared (zero).

A reserved 4-bit operand field must read all ones. When it does not, or when the length and class do not form a legal combination, the stage flags an illegal encoding and returns the old destination unchanged. The caller supplies the old destination value alongside the source, so the stage has no register file of its own.

Top module: `vdup_stage`

## Requirements
- R1: `out_valid`, `dst` and `illegal` are registered one clock edge after a cycle with `in_valid` high; `out_valid` is low after any edge where `in_valid` was low. A synchronous active-high `rst` clears `out_valid` and `illegal`.
- R2: For each lane pair (2m, 2m+1) inside the active length, both destination lanes take source lane 2m. Lane k occupies bits 64k+63:64k.
- R3: `vlen_sel` code 0 selects 128 bits (2 lanes), code 1 selects 256 bits (4 lanes), and code 2 selects 512 bits (8 lanes).
- R4: In the masked class (`enc_sel` = 2), an active lane receives the duplicated value when its mask bit is set or when `mask_en` is low.
- R5: In the masked class with `mask_en` high and `zero_mode` low, an active lane whose mask bit is clear keeps its `old_dst` lane.
- R6: In the masked class with `mask_en` high and `zero_mode` high, an active lane whose mask bit is clear becomes zero.
- R7: In the masked and unmasked (`enc_sel` = 1) classes, every destination bit above the active length is zero.
- R8: In the legacy class (`enc_sel` = 0), with `vlen_sel` = 0, destination bits 511:128 equal `old_dst` bits 511:128.
- R9: The unmasked class ignores `mask`, `mask_en` and `zero_mode`.
- R10: If `rsv` is not 4'b1111, `illegal` is raised with the result and `dst` equals `old_dst`.
- R11: Certain combinations also raise `illegal` and return `old_dst` unchanged:
  - `vlen_sel` = 2 with a class other than masked;
  - the legacy class with `vlen_sel` other than 0;
  - `enc_sel` = 3;
  - `vlen_sel` = 3.
- R12: In the masked class, mask bits at or above the active lane count have no effect on `dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| src | input | 512 | Source vector, lane k at bits 64k+63:64k |
| old_dst | input | 512 | Current destination value |
| vlen_sel | input | 2 | Vector length code (0: 128, 1: 256, 2: 512) |
| enc_sel | input | 2 | Encoding class (0: legacy, 1: unmasked, 2: masked) |
| mask | input | 8 | Per-lane writemask, bit k for lane k |
| mask_en | input | 1 | Writemask applied when high |
| zero_mode | input | 1 | 1: clear masked-off lanes, 0: merge |
| rsv | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | New destination vector |
| illegal | output | 1 | Illegal encoding flag for this result |

## Verification
The stage keeps no state across operations beyond its output registers. A wrong lane decision therefore shows in `dst` on the very next cycle after the request, and stays there until the next request. A decoder that drives the wrong operation for a lane appears in a single 64-bit slice of `dst`: a stale old value, a zero, or the odd source lane instead of the even one. A fault in the legality check shows at once as a wrong `illegal` bit and as `dst` departing from `old_dst`. The directed scenarios use distinct values per lane in both `src` and `old_dst`, so every one of these faults leaves a visible mismatch.

// File: rtl/vdup_pkg.sv
package vdup_pkg;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_BAD = 2'd3
  } vlen_e;

  typedef enum logic [1:0] {
    CLS_LEGACY   = 2'd0,
    CLS_UNMASKED = 2'd1,
    CLS_MASKED   = 2'd2,
    CLS_BAD      = 2'd3
  } enc_e;

  // Per-lane action chosen by the control decoder.
  typedef enum logic [1:0] {
    LOP_KEEP = 2'd0,
    LOP_DUP  = 2'd1,
    LOP_ZERO = 2'd2
  } lane_op_e;

endpackage

// File: rtl/vdup_ctrl.sv
module vdup_ctrl
  import vdup_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int RSV_W     = 4
) (
  input  logic [1:0]                vlen_sel,
  input  logic [1:0]                enc_sel,
  input  logic [NUM_LANES-1:0]      mask,
  input  logic                      mask_en,
  input  logic                      zero_mode,
  input  logic [RSV_W-1:0]          rsv,
  output logic                      bad_enc,
  output logic [NUM_LANES-1:0][1:0] lane_ops
);

  localparam int CNT_W = $clog2(NUM_LANES) + 1;

  vlen_e            vl;
  enc_e             cls;
  logic [CNT_W-1:0] act_cnt;

  assign vl  = vlen_e'(vlen_sel);
  assign cls = enc_e'(enc_sel);

  // Active lane count per length code.
  always_comb begin
    case (vl)
      VL_128:  act_cnt = CNT_W'(2);
      VL_256:  act_cnt = CNT_W'(4);
      VL_512:  act_cnt = CNT_W'(8);
      default: act_cnt = '0;
    endcase
  end

  // Legality of the reserved field and of the length/class pairing.
  always_comb begin
    bad_enc = (rsv != {RSV_W{1'b1}});
    if (cls == CLS_BAD || vl == VL_BAD)            bad_enc = 1'b1;
    if (vl == VL_512 && cls != CLS_MASKED)         bad_enc = 1'b1;
    if (cls == CLS_LEGACY && vl != VL_128)         bad_enc = 1'b1;
  end

  // Per-lane decision.
  always_comb begin
    for (int j = 0; j < NUM_LANES; j++) begin
      if (bad_enc) begin
        lane_ops[j] = LOP_KEEP;
      end else if (CNT_W'(j) < act_cnt) begin
        if (cls == CLS_MASKED && mask_en && !mask[j])
          lane_ops[j] = zero_mode ? LOP_ZERO : LOP_KEEP;
        else
          lane_ops[j] = LOP_DUP;
      end else begin
        lane_ops[j] = (cls == CLS_LEGACY) ? LOP_KEEP : LOP_ZERO;
      end
    end
  end

endmodule

// File: rtl/vdup_lane.sv
module vdup_lane
  import vdup_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [1:0]        op,
  input  logic [LANE_W-1:0] dup_val,
  input  logic [LANE_W-1:0] old_val,
  output logic [LANE_W-1:0] res
);

  always_comb begin
    case (lane_op_e'(op))
      LOP_DUP:  res = dup_val;
      LOP_ZERO: res = '0;
      default:  res = old_val;
    endcase
  end

endmodule

// File: rtl/vdup_stage.sv
module vdup_stage
  import vdup_pkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int NUM_LANES = 8,
  parameter int RSV_W     = 4,
  localparam int VW       = LANE_W * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [VW-1:0]        src,
  input  logic [VW-1:0]        old_dst,
  input  logic [1:0]           vlen_sel,
  input  logic [1:0]           enc_sel,
  input  logic [NUM_LANES-1:0] mask,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  input  logic [RSV_W-1:0]     rsv,
  output logic                 out_valid,
  output logic [VW-1:0]        dst,
  output logic                 illegal
);

  logic                      bad_enc;
  logic [NUM_LANES-1:0][1:0] lane_ops;
  logic [VW-1:0]             next_dst;

  vdup_ctrl #(
    .NUM_LANES (NUM_LANES),
    .RSV_W     (RSV_W)
  ) u_ctrl (
    .vlen_sel  (vlen_sel),
    .enc_sel   (enc_sel),
    .mask      (mask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .rsv       (rsv),
    .bad_enc   (bad_enc),
    .lane_ops  (lane_ops)
  );

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    localparam int EVEN = (j / 2) * 2;
    vdup_lane #(
      .LANE_W (LANE_W)
    ) u_lane (
      .op      (lane_ops[j]),
      .dup_val (src[EVEN*LANE_W +: LANE_W]),
      .old_val (old_dst[j*LANE_W +: LANE_W]),
      .res     (next_dst[j*LANE_W +: LANE_W])
    );
  end

  // Control flags carry reset; the wide datapath register does not.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & bad_enc;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) dst <= next_dst;
  end

endmodule

// File: rtl/vdup_stage_chk.sv
module vdup_stage_chk #(
  parameter int VW        = 512,
  parameter int NUM_LANES = 8,
  parameter int RSV_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [VW-1:0]        src,
  input logic [VW-1:0]        old_dst,
  input logic [1:0]           vlen_sel,
  input logic [1:0]           enc_sel,
  input logic                 mask_en,
  input logic [RSV_W-1:0]     rsv,
  input logic                 out_valid,
  input logic [VW-1:0]        dst,
  input logic                 illegal
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: reset clears the flags on the following edge
  always @(negedge clk) begin
    if (rst_q) begin
      a_r1_reset_clear : assert (!out_valid && !illegal);
    end
  end

  a_r1_valid_follows : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_valid_drops : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !illegal));

  a_r10_rsv_keeps : assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv != {RSV_W{1'b1}}) |=> (illegal && dst == $past(old_dst)));

  a_r2_pair_dup : assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv == {RSV_W{1'b1}} && enc_sel == 2'd1 && vlen_sel == 2'd1)
    |=> (dst[127:64] == $past(src[63:0]) && dst[255:192] == $past(src[191:128])
         && !illegal));

  a_r7_upper_zero : assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv == {RSV_W{1'b1}} && enc_sel == 2'd1 && vlen_sel == 2'd0)
    |=> (dst[VW-1:128] == '0));

  a_r8_legacy_upper : assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv == {RSV_W{1'b1}} && enc_sel == 2'd0 && vlen_sel == 2'd0)
    |=> (dst[VW-1:128] == $past(old_dst[VW-1:128])));

  a_r11_wide_unmasked : assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'd2 && enc_sel != 2'd2)
    |=> (illegal && dst == $past(old_dst)));

  a_r4_nomask_full : assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsv == {RSV_W{1'b1}} && enc_sel == 2'd2 && vlen_sel == 2'd2 && !mask_en)
    |=> (dst[511:448] == $past(src[447:384])));

endmodule

bind vdup_stage vdup_stage_chk #(
  .VW        (LANE_W * NUM_LANES),
  .NUM_LANES (NUM_LANES),
  .RSV_W     (RSV_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .src       (src),
  .old_dst   (old_dst),
  .vlen_sel  (vlen_sel),
  .enc_sel   (enc_sel),
  .mask_en   (mask_en),
  .rsv       (rsv),
  .out_valid (out_valid),
  .dst       (dst),
  .illegal   (illegal)
);

// File: tb/vdup_stage_bench.sv
module vdup_stage_bench;

  localparam int CLK_P = 10;
  localparam int VW    = 512;
  localparam int NL    = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [VW-1:0] src, old_dst;
  logic [1:0]    vlen_sel, enc_sel;
  logic [NL-1:0] mask;
  logic          mask_en, zero_mode;
  logic [3:0]    rsv;
  logic          out_valid, illegal;
  logic [VW-1:0] dst;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vdup_stage u_vdup_stage (
    .clk (clk), .rst (rst), .in_valid (in_valid), .src (src),
    .old_dst (old_dst), .vlen_sel (vlen_sel), .enc_sel (enc_sel),
    .mask (mask), .mask_en (mask_en), .zero_mode (zero_mode), .rsv (rsv),
    .out_valid (out_valid), .dst (dst), .illegal (illegal)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check_bit(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [VW-1:0] got,
                           input logic [VW-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic is_bad(input logic [1:0] vl, input logic [1:0] ec,
                                  input logic [3:0] rs);
    return (rs != 4'hF) || (ec == 2'd3) || (vl == 2'd3) ||
           (vl == 2'd2 && ec != 2'd2) || (ec == 2'd0 && vl != 2'd0);
  endfunction

  function automatic logic [VW-1:0] model(
      input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [1:0] vl,
      input logic [1:0] ec, input logic [NL-1:0] m, input logic me,
      input logic zm, input logic [3:0] rs);
    logic [VW-1:0] r;
    int act;
    if (is_bad(vl, ec, rs)) return o;
    act = 2 << vl;
    for (int j = 0; j < NL; j++) begin
      if (j < act) begin
        if (ec == 2'd2 && me && !m[j])
          r[j*64 +: 64] = zm ? 64'd0 : o[j*64 +: 64];
        else
          r[j*64 +: 64] = s[(j/2)*2*64 +: 64];
      end else begin
        r[j*64 +: 64] = (ec == 2'd0) ? o[j*64 +: 64] : 64'd0;
      end
    end
    return r;
  endfunction

  // One request, then check the registered result one edge later.
  task automatic run_op(input string tag, input logic [1:0] vl, input logic [1:0] ec,
                        input logic [NL-1:0] m, input logic me, input logic zm,
                        input logic [3:0] rs, input int seed);
    logic [VW-1:0] exp_d;
    @(negedge clk);
    for (int k = 0; k < NL; k++) begin
      src[k*64 +: 64]     = {24'h5EED00, 8'(seed), 24'h0, 8'(k)};
      old_dst[k*64 +: 64] = {24'h01D000, 8'(seed), 24'h0, 8'(k + 16)};
    end
    vlen_sel = vl; enc_sel = ec; mask = m; mask_en = me; zero_mode = zm; rsv = rs;
    in_valid = 1'b1;
    exp_d = model(src, old_dst, vl, ec, m, me, zm, rs);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check_bit({tag, " illegal"}, illegal, is_bad(vl, ec, rs));
    check_vec({tag, " dst"}, dst, exp_d);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; rsv = 4'h0; vlen_sel = 2'd0; enc_sel = 2'd1;
    mask = '0; mask_en = 1'b0; zero_mode = 1'b0; src = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check_bit("R1 reset out_valid", out_valid, 1'b0);
    check_bit("R1 reset illegal", illegal, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_unmasked_128;  run_op("R2 R3 R7 unmasked 128", 2'd0, 2'd1, 8'h00, 1'b0, 1'b0, 4'hF, 1); endtask
  task automatic t_unmasked_256;  run_op("R2 R3 R7 unmasked 256", 2'd1, 2'd1, 8'h00, 1'b0, 1'b0, 4'hF, 2); endtask
  task automatic t_masked_full;   run_op("R3 R4 masked 512 no mask", 2'd2, 2'd2, 8'h00, 1'b0, 1'b1, 4'hF, 3); endtask
  task automatic t_masked_merge;  run_op("R5 masked merge", 2'd2, 2'd2, 8'hA5, 1'b1, 1'b0, 4'hF, 4); endtask
  task automatic t_masked_zero;   run_op("R6 masked zero", 2'd2, 2'd2, 8'h3C, 1'b1, 1'b1, 4'hF, 5); endtask
  task automatic t_mask_upper;    run_op("R12 R7 upper mask ignored", 2'd1, 2'd2, 8'hF0, 1'b1, 1'b0, 4'hF, 6); endtask
  task automatic t_mask_upper128; run_op("R12 R4 upper mask ignored 128", 2'd0, 2'd2, 8'hFC, 1'b1, 1'b1, 4'hF, 7); endtask
  task automatic t_legacy;        run_op("R8 legacy upper kept", 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 4'hF, 8); endtask
  task automatic t_unmasked_ign;  run_op("R9 unmasked ignores mask", 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 4'hF, 9); endtask
  task automatic t_rsv_bad;       run_op("R10 reserved field", 2'd2, 2'd2, 8'hFF, 1'b0, 1'b0, 4'hE, 10); endtask
  task automatic t_wide_unmasked; run_op("R11 512 unmasked", 2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 4'hF, 11); endtask
  task automatic t_legacy_256;    run_op("R11 legacy 256", 2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 4'hF, 12); endtask
  task automatic t_class_code3;   run_op("R11 class code 3", 2'd0, 2'd3, 8'h00, 1'b0, 1'b0, 4'hF, 13); endtask

  task automatic t_idle;
    logic [VW-1:0] held;
    run_op("R1 before idle", 2'd0, 2'd1, 8'h00, 1'b0, 1'b0, 4'h0, 14);
    held = dst;
    @(negedge clk);
    check_bit("R1 idle out_valid", out_valid, 1'b0);
    check_bit("R1 idle illegal", illegal, 1'b0);
    check_vec("R1 idle dst held", dst, held);
  endtask

  initial begin
    t_reset;
    t_unmasked_128;
    t_unmasked_256;
    t_masked_full;
    t_masked_merge;
    t_masked_zero;
    t_mask_upper;
    t_mask_upper128;
    t_legacy;
    t_unmasked_ign;
    t_rsv_bad;
    t_wide_unmasked;
    t_legacy_256;
    t_class_code3;
    t_idle;
    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule